// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A fully synchronous up counter, four bits wide by default, whose bits all change together on the rising clock edge. Software-free control comes from four level inputs sampled at that edge. An active-low clear forces zero, an active-low load copies a data word into the count, and two count enables must both be high for the count to advance. When none of these applies, the count holds.

A carry output goes high while the count is all ones and the chaining enable is high. The other enable has no effect on it. Several counters can therefore be stacked into a wider synchronous counter with no extra gates. Each stage's chaining enable takes the carry of the stage below, and every stage shares the clock and the parallel enable. Feeding an active-low decode of one count value back into the clear input shortens the sequence to a smaller modulus.

Top module: `sync_counter`

## Requirements
- R1: The count changes only at a rising clock edge, with all bits updating together; between edges the output is steady whatever the control inputs do.
- R2: With `clr_n` low at an edge, the count becomes 0 whatever `ld_n`, `cnt_en` and `chain_en` are.
- R3: With `clr_n` high and `ld_n` low at an edge, the count becomes `din` whatever the two enables are.
- R4: With `clr_n` and `ld_n` high and both `cnt_en` and `chain_en` high at an edge, the count increases by one.
- R5: Incrementing from all ones (15) gives 0.
- R6: With `clr_n` and `ld_n` high and either enable low at an edge, the count keeps its value.
- R7: `carry_out` is 1 exactly when the count is all ones and `chain_en` is 1; `cnt_en` has no effect on it.
- R8: Three stages chained (each upper `chain_en` driven by the lower `carry_out`, shared clock and `cnt_en`) step through every 12-bit value in order and wrap to 0.
- R9: Only the enable levels present at the edge matter; pulses on `cnt_en` in mid-cycle leave the result unchanged.
- R10: Driving `clr_n` from the active-low decode of count 9 makes the counter cycle 0 to 9 and back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous load of `din`, active low |
| cnt_en | input | 1 | Parallel count enable |
| chain_en | input | 1 | Chaining count enable, also gates the carry |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Count |
| carry_out | output | 1 | High while count is all ones and `chain_en` is high |

## Verification
Clear and load can both be requested at the same edge, and so can load and a count with both enables high. The bench drives both `clr_n` and `ld_n` low with a nonzero `din` and expects zero. It also asserts load with both enables high and expects exactly `din`, not `din+1`. The carry is then judged at all ones with each enable lowered in turn. Only lowering `chain_en` may drop it.

// File: rtl/sync_counter_pkg.sv
package sync_counter_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } ctr_op_e;
endpackage

// File: rtl/sync_counter_op_decode.sv
module sync_counter_op_decode
   import sync_counter_pkg::*;
(
   input  logic    clr_n,
   input  logic    ld_n,
   input  logic    cnt_en,
   input  logic    chain_en,
   output ctr_op_e op
);
   always_comb begin
      if (!clr_n)                    op = OP_CLEAR;
      else if (!ld_n)                op = OP_LOAD;
      else if (cnt_en && chain_en)   op = OP_COUNT;
      else                           op = OP_HOLD;
   end
endmodule

// File: rtl/sync_counter_state.sv
module sync_counter_state
   import sync_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
)(
   input  logic             clk,
   input  ctr_op_e          op,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] q_inc;

   generate
      if (LOOKAHEAD) begin : g_lookahead
         logic [WIDTH-1:0] tgl;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
               assign tgl[i] = 1'b1;
            end else begin : g_up
               assign tgl[i] = tgl[i-1] & q[i-1];
            end
            assign q_inc[i] = q[i] ^ tgl[i];
         end
      end else begin : g_adder
         assign q_inc = q + WIDTH'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      case (op)
         OP_CLEAR: q <= '0;
         OP_LOAD:  q <= din;
         OP_COUNT: q <= q_inc;
         default:  q <= q;
      endcase
   end
endmodule

// File: rtl/sync_counter_carry.sv
module sync_counter_carry #(
   parameter int WIDTH = 4
)(
   input  logic [WIDTH-1:0] q,
   input  logic             chain_en,
   output logic             carry_out
);
   assign carry_out = chain_en & (&q);
endmodule

// File: rtl/sync_counter.sv
module sync_counter
   import sync_counter_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
)(
   input  logic             clk,
   input  logic             clr_n,
   input  logic             ld_n,
   input  logic             cnt_en,
   input  logic             chain_en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sync_counter: WIDTH must be at least 1");
      end
   endgenerate

   ctr_op_e op;

   sync_counter_op_decode u_dec (
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .cnt_en   (cnt_en),
      .chain_en (chain_en),
      .op       (op)
   );

   sync_counter_state #(.WIDTH(WIDTH), .LOOKAHEAD(LOOKAHEAD)) u_state (
      .clk (clk),
      .op  (op),
      .din (din),
      .q   (q)
   );

   sync_counter_carry #(.WIDTH(WIDTH)) u_carry (
      .q         (q),
      .chain_en  (chain_en),
      .carry_out (carry_out)
   );
endmodule

// File: rtl/sync_counter_checker.sv
module sync_counter_checker #(
   parameter int WIDTH = 4
)(
   input logic             clk,
   input logic             clr_n,
   input logic             ld_n,
   input logic             cnt_en,
   input logic             chain_en,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry_out
);
   logic primed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!primed)
      !clr_n |=> (q == '0));                                               // R2
   AST_LOAD_DIN: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && !ld_n) |=> (q == $past(din)));                             // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && cnt_en && chain_en) |=> (q == $past(q) + WIDTH'(1))); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && !(cnt_en && chain_en)) |=> $stable(q));            // R6
   AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!primed)
      carry_out |-> (q == '1 && chain_en));                                // R7
   AST_CARRY_SEEN: assert property (@(posedge clk) disable iff (!primed)
      (q == '1 && chain_en) |-> carry_out);                                // R7
endmodule

bind sync_counter sync_counter_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .ld_n      (ld_n),
   .cnt_en    (cnt_en),
   .chain_en  (chain_en),
   .din       (din),
   .q         (q),
   .carry_out (carry_out)
);

// File: tb/sync_counter_bench.sv
`timescale 1ns/1ps
module sync_counter_bench;
   localparam int W      = 4;
   localparam int NST    = 3;
   localparam int CW     = W * NST;
   localparam int NVEC   = 14;

   int n_cmp  = 0;
   int n_fail = 0;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   // single stage
   logic         clr_tb = 1'b1, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
   logic         mod_mode = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic         carry_out;
   logic         clr_n;
   assign clr_n = mod_mode ? ~(q == 4'd9) : clr_tb;

   sync_counter #(.WIDTH(W)) u_sync_counter (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
      .chain_en(chain_en), .din(din), .q(q), .carry_out(carry_out)
   );

   // cascade
   logic              cas_clr = 1'b1, cas_en = 1'b0;
   logic [NST-1:0]    cas_carry;
   logic [NST-1:0]    cas_chain;
   logic [CW-1:0]     cas_q;
   for (genvar g = 0; g < NST; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign cas_chain[g] = 1'b1;
      end else begin : g_next
         assign cas_chain[g] = cas_carry[g-1];
      end
      sync_counter #(.WIDTH(W), .LOOKAHEAD(g % 2 == 0)) u_stage (
         .clk(clk), .clr_n(cas_clr), .ld_n(1'b1), .cnt_en(cas_en),
         .chain_en(cas_chain[g]), .din('0),
         .q(cas_q[g*W +: W]), .carry_out(cas_carry[g])
      );
   end

   // {clr_n, ld_n, cnt_en, chain_en, din, exp_q, exp_carry}
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0,1'b1,1'b1,1'b1,4'd5, 4'd0, 1'b0},  // R2
      {1'b0,1'b0,1'b1,1'b1,4'd9, 4'd0, 1'b0},  // R2 over load
      {1'b1,1'b0,1'b0,1'b0,4'd9, 4'd9, 1'b0},  // R3
      {1'b1,1'b1,1'b1,1'b1,4'd0, 4'd10,1'b0},  // R4
      {1'b1,1'b1,1'b0,1'b1,4'd0, 4'd10,1'b0},  // R6
      {1'b1,1'b1,1'b1,1'b0,4'd0, 4'd10,1'b0},  // R6
      {1'b1,1'b0,1'b1,1'b1,4'd14,4'd14,1'b0},  // R3 over count
      {1'b1,1'b1,1'b1,1'b1,4'd0, 4'd15,1'b1},  // R4 R7
      {1'b1,1'b1,1'b0,1'b1,4'd0, 4'd15,1'b1},  // R7 cnt_en ignored
      {1'b1,1'b1,1'b1,1'b0,4'd0, 4'd15,1'b0},  // R7
      {1'b1,1'b1,1'b1,1'b1,4'd0, 4'd0, 1'b0},  // R5
      {1'b1,1'b0,1'b0,1'b0,4'd15,4'd15,1'b0},  // R3 R7
      {1'b0,1'b0,1'b1,1'b1,4'd3, 4'd0, 1'b0},  // R2
      {1'b1,1'b1,1'b1,1'b1,4'd0, 4'd1, 1'b0}   // R4
   };

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      // table walk: inputs set mid-cycle, result read mid-cycle after edge
      @(posedge clk); #5;
      for (int i = 0; i < NVEC; i++) begin
         {clr_tb, ld_n, cnt_en, chain_en, din} = VEC[i][12:5];
         @(posedge clk); #5;
         check($sformatf("R2-6 vec%0d q", i), int'(q), int'(VEC[i][4:1]));
         check($sformatf("R7 vec%0d carry", i), int'(carry_out), int'(VEC[i][0]));
      end

      // R1: q steady between edges while counting enabled
      clr_tb = 1; ld_n = 1; cnt_en = 1; chain_en = 1;
      @(posedge clk); #2;
      begin
         logic [W-1:0] snap;
         snap = q;
         #14;
         check("R1 steady mid-cycle", int'(q), int'(snap));
      end

      // R9: enable pulsed low mid-cycle, high at edge -> counts
      @(posedge clk); #5;
      ld_n = 0; din = 4'd6; cnt_en = 0; chain_en = 0;
      @(posedge clk); #5;
      ld_n = 1; cnt_en = 1; chain_en = 1;
      #3 cnt_en = 0; #3 cnt_en = 1;
      @(posedge clk); #5;
      check("R9 low pulse ignored", int'(q), 7);
      // R9: enable pulsed high mid-cycle, low at edge -> holds
      cnt_en = 0;
      #3 cnt_en = 1; #3 cnt_en = 0;
      @(posedge clk); #5;
      check("R9 high pulse ignored", int'(q), 7);

      // R10: modulus-10 via decode into clear
      clr_tb = 0;
      @(posedge clk); #5;
      clr_tb = 1; cnt_en = 1; chain_en = 1; mod_mode = 1;
      for (int k = 1; k <= 25; k++) begin
         @(posedge clk); #5;
         check("R10 mod10", int'(q), k % 10);
      end
      mod_mode = 0;

      // R8: three-stage cascade
      cas_clr = 0;
      @(posedge clk); #5;
      cas_clr = 1; cas_en = 1;
      check("R8 cascade clear", int'(cas_q), 0);
      for (int k = 1; k <= (1 << CW); k++) begin
         @(posedge clk); #5;
         check("R8 cascade count", int'(cas_q), k % (1 << CW));
         if (k == (1 << CW) - 1)
            check("R8 top carry at max", int'(cas_carry[NST-1]), 1);
      end
      check("R8 top carry after wrap", int'(cas_carry[NST-1]), 0);
      cas_en = 0;
      @(posedge clk); #5;
      check("R8 cascade hold", int'(cas_q), 0);

      summary();
   end
endmodule